// File: doc/BRIEF.md
# GPIO Port With Commit Protection

This block is the register side of an eight-pin general-purpose I/O port. Software reaches it through a single-cycle word bus: a write strobe, a register index, write data and a combinational read-data return. It stores the output data, direction, alternate-function enable, a four-bit peripheral selector per pin, pull-up and pull-down requests, digital input enable and analog select. For every pin it decides whether the pad is driven by the software data value or by one of up to sixteen peripheral sources, and it returns the gated pad input both to software and to the peripherals.

Some pins carry debug or non-maskable-interrupt duties and are protected (by default pins 0 to 3 for debug and pin 7 for the interrupt). On those pins, a bus write to the alternate-function, pull-up, pull-down or digital-enable registers changes a bit only when two conditions hold. The port must have been opened with a 32-bit key, and the pin's bit in the commit register must be set. The commit register can itself be changed only while the port is open. This keeps a stray write from stealing the debug pins.

Top module: `gpioCommitPort`

## Requirements
- R1: After reset the lock register (index 8) reads 1. The alternate-function (index 2) and digital-enable (index 5) registers read the protected-pin mask. The commit register (index 9) reads the inverse of that mask. The selector register (index 7) holds 1 in the nibble of each protected pin and 0 elsewhere. Data (0), direction (1), pull-up (3), pull-down (4) and analog (6) read 0.
- R2: A pin with its alternate-function bit clear drives padOut from its data bit and padOe from its direction bit.
- R3: A pin with its alternate-function bit set uses its selector nibble (bits 4p+3..4p of index 7) to pick peripheral k. padOut then takes perOut[16p+k] and padOe takes perOe[16p+k]. Selector value 0 drives 0 with the output disabled.
- R4: Writing 0x4C4F434B to index 8 opens the port, and the lock register then reads 0. Writing any other value closes it, and the register reads 1 again.
- R5: Writes to the commit register are discarded while the port is closed. Its bits for unprotected pins always read 1.
- R6: On protected pins, writes to indices 2, 3, 4 and 5 change a bit only while the port is open and that pin's commit bit is 1. On unprotected pins they always take effect.
- R7: The data, direction, analog and selector registers are written unconditionally on every pin.
- R8: perIn equals padIn ANDed with the digital-enable register.
- R9: padAnaEn, padPullUp and padPullDn follow the analog, pull-up and pull-down registers bit for bit.
- R10: Reading index 0 returns the data bit for pins in software mode with direction 1. For every other pin it returns the gated pad input. Unmapped indices (10 to 15) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe |
| busAddr | input | 4 | Register index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output levels |
| padOe | output | 8 | Pad output enables |
| padPullUp | output | 8 | Pull-up requests |
| padPullDn | output | 8 | Pull-down requests |
| padAnaEn | output | 8 | Analog isolation release per pin |
| perIn | output | 8 | Gated pad input to peripherals |
| perOut | input | 128 | Peripheral output, bit 16*pin+function |
| perOe | input | 128 | Peripheral output enable, bit 16*pin+function |

## Verification
The hardest state to reach is a protected-pin write that lands while the port is open and only part of the commit mask is set. A write there must split bit by bit between taking effect and being discarded. Random stimulus rarely produces the key, so the sequence injects it with a fixed probability. It also writes the commit register in both the open and closed states. This lets open and closed ports meet partial commit masks in many combinations. Directed steps add a write to a protected pin before any commit, a commit write made while closed, and a relock that follows a commit.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;
  localparam int IDX_W = 4;
  localparam logic [31:0] UNLOCK_KEY = 32'h4C4F434B;

  typedef enum logic [IDX_W-1:0] {
    IDX_DATA   = 4'd0,
    IDX_DIR    = 4'd1,
    IDX_ALT    = 4'd2,
    IDX_PU     = 4'd3,
    IDX_PD     = 4'd4,
    IDX_DEN    = 4'd5,
    IDX_ANA    = 4'd6,
    IDX_CTL    = 4'd7,
    IDX_LOCK   = 4'd8,
    IDX_COMMIT = 4'd9
  } regIdxE;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrAlt;
    logic wrPu;
    logic wrPd;
    logic wrDen;
    logic wrAna;
    logic wrCtl;
    logic wrCommit;
  } wrStrobeT;
endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [IDX_W-1:0]  busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output wrStrobeT          strb,
  output logic              lockOpen
);
  logic keyMatch;
  logic lockWr;

  assign keyMatch = (busWdata == DATA_W'(UNLOCK_KEY));
  assign lockWr   = busWr && (busAddr == IDX_LOCK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockOpen <= 1'b0;
    else if (lockWr) lockOpen <= keyMatch;
  end

  always_comb begin
    strb          = '0;
    strb.wrData   = busWr && (busAddr == IDX_DATA);
    strb.wrDir    = busWr && (busAddr == IDX_DIR);
    strb.wrAlt    = busWr && (busAddr == IDX_ALT);
    strb.wrPu     = busWr && (busAddr == IDX_PU);
    strb.wrPd     = busWr && (busAddr == IDX_PD);
    strb.wrDen    = busWr && (busAddr == IDX_DEN);
    strb.wrAna    = busWr && (busAddr == IDX_ANA);
    strb.wrCtl    = busWr && (busAddr == IDX_CTL);
    strb.wrCommit = busWr && (busAddr == IDX_COMMIT) && lockOpen;
  end
endmodule

// File: rtl/gpioPortRegs.sv
module gpioPortRegs
  import gpioPortPkg::*;
#(
  parameter int                NUM_PINS  = 8,
  parameter int                SEL_W     = 4,
  parameter int                DATA_W    = 32,
  parameter logic [NUM_PINS-1:0] PROT_MASK = 8'h8F,
  parameter logic [SEL_W-1:0]  RST_FUNC  = 4'd1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wrStrobeT                  strb,
  input  logic                      lockOpen,
  input  logic [IDX_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]         busWdata,
  input  logic [NUM_PINS-1:0]       pinIn,
  output logic [DATA_W-1:0]         busRdata,
  output logic [NUM_PINS-1:0]       dataQ,
  output logic [NUM_PINS-1:0]       dirQ,
  output logic [NUM_PINS-1:0]       altQ,
  output logic [NUM_PINS-1:0]       puQ,
  output logic [NUM_PINS-1:0]       pdQ,
  output logic [NUM_PINS-1:0]       denQ,
  output logic [NUM_PINS-1:0]       anaQ,
  output logic [NUM_PINS*SEL_W-1:0] ctlQ,
  output logic [NUM_PINS-1:0]       commitQ
);
  localparam int CTL_W = NUM_PINS * SEL_W;

  function automatic logic [CTL_W-1:0] ctlResetVal();
    logic [CTL_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (PROT_MASK[i]) v[i*SEL_W +: SEL_W] = RST_FUNC;
    return v;
  endfunction

  localparam logic [CTL_W-1:0] CTL_RST = ctlResetVal();

  logic [NUM_PINS-1:0] wd;
  logic [NUM_PINS-1:0] allow;
  logic [NUM_PINS-1:0] swDrive;
  logic [NUM_PINS-1:0] dataRd;

  assign wd    = busWdata[NUM_PINS-1:0];
  assign allow = ~PROT_MASK | (lockOpen ? commitQ : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      dirQ    <= '0;
      altQ    <= PROT_MASK;
      puQ     <= '0;
      pdQ     <= '0;
      denQ    <= PROT_MASK;
      anaQ    <= '0;
      ctlQ    <= CTL_RST;
      commitQ <= ~PROT_MASK;
    end else begin
      if (strb.wrData)   dataQ   <= wd;
      if (strb.wrDir)    dirQ    <= wd;
      if (strb.wrAna)    anaQ    <= wd;
      if (strb.wrCtl)    ctlQ    <= busWdata[CTL_W-1:0];
      if (strb.wrAlt)    altQ    <= (altQ & ~allow) | (wd & allow);
      if (strb.wrPu)     puQ     <= (puQ  & ~allow) | (wd & allow);
      if (strb.wrPd)     pdQ     <= (pdQ  & ~allow) | (wd & allow);
      if (strb.wrDen)    denQ    <= (denQ & ~allow) | (wd & allow);
      if (strb.wrCommit) commitQ <= wd | ~PROT_MASK;
    end
  end

  assign swDrive = ~altQ & dirQ;
  assign dataRd  = (dataQ & swDrive) | (pinIn & ~swDrive);

  always_comb begin
    unique case (busAddr)
      IDX_DATA:   busRdata = DATA_W'(dataRd);
      IDX_DIR:    busRdata = DATA_W'(dirQ);
      IDX_ALT:    busRdata = DATA_W'(altQ);
      IDX_PU:     busRdata = DATA_W'(puQ);
      IDX_PD:     busRdata = DATA_W'(pdQ);
      IDX_DEN:    busRdata = DATA_W'(denQ);
      IDX_ANA:    busRdata = DATA_W'(anaQ);
      IDX_CTL:    busRdata = DATA_W'(ctlQ);
      IDX_LOCK:   busRdata = DATA_W'(!lockOpen);
      IDX_COMMIT: busRdata = DATA_W'(commitQ);
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpioPinMux.sv
module gpioPinMux #(
  parameter int NUM_FUNCS = 16,
  parameter int SEL_W     = 4
) (
  input  logic                 altSel,
  input  logic                 dataBit,
  input  logic                 dirBit,
  input  logic [SEL_W-1:0]     funcSel,
  input  logic [NUM_FUNCS-1:0] funcOut,
  input  logic [NUM_FUNCS-1:0] funcOe,
  output logic                 pinOut,
  output logic                 pinOe
);
  logic hasFunc;
  assign hasFunc = (funcSel != '0);

  always_comb begin
    if (!altSel) begin
      pinOut = dataBit;
      pinOe  = dirBit;
    end else if (hasFunc) begin
      pinOut = funcOut[funcSel];
      pinOe  = funcOe[funcSel];
    end else begin
      pinOut = 1'b0;
      pinOe  = 1'b0;
    end
  end
endmodule

// File: rtl/gpioCommitPort.sv
module gpioCommitPort
  import gpioPortPkg::*;
#(
  parameter int                  NUM_PINS  = 8,
  parameter int                  NUM_FUNCS = 16,
  parameter int                  DATA_W    = 32,
  parameter logic [NUM_PINS-1:0] PROT_MASK = 8'h8F,
  parameter logic [3:0]          RST_FUNC  = 4'd1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWr,
  input  logic [3:0]                    busAddr,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  input  logic [NUM_PINS-1:0]           padIn,
  output logic [NUM_PINS-1:0]           padOut,
  output logic [NUM_PINS-1:0]           padOe,
  output logic [NUM_PINS-1:0]           padPullUp,
  output logic [NUM_PINS-1:0]           padPullDn,
  output logic [NUM_PINS-1:0]           padAnaEn,
  output logic [NUM_PINS-1:0]           perIn,
  input  logic [NUM_PINS*NUM_FUNCS-1:0] perOut,
  input  logic [NUM_PINS*NUM_FUNCS-1:0] perOe
);
  localparam int SEL_W = $clog2(NUM_FUNCS);

  wrStrobeT                  strb;
  logic                      lockOpen;
  logic [NUM_PINS-1:0]       dataQ, dirQ, altQ, puQ, pdQ, denQ, anaQ, commitQ;
  logic [NUM_PINS*SEL_W-1:0] ctlQ;

  gpioPortCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .strb(strb), .lockOpen(lockOpen)
  );

  gpioPortRegs #(
    .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .PROT_MASK(PROT_MASK), .RST_FUNC(SEL_W'(RST_FUNC))
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .lockOpen(lockOpen),
    .busAddr(busAddr), .busWdata(busWdata), .pinIn(perIn),
    .busRdata(busRdata), .dataQ(dataQ), .dirQ(dirQ), .altQ(altQ),
    .puQ(puQ), .pdQ(pdQ), .denQ(denQ), .anaQ(anaQ), .ctlQ(ctlQ),
    .commitQ(commitQ)
  );

  assign perIn     = padIn & denQ;
  assign padPullUp = puQ;
  assign padPullDn = pdQ;
  assign padAnaEn  = anaQ;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpioPinMux #(.NUM_FUNCS(NUM_FUNCS), .SEL_W(SEL_W)) u_mux (
      .altSel(altQ[p]), .dataBit(dataQ[p]), .dirBit(dirQ[p]),
      .funcSel(ctlQ[p*SEL_W +: SEL_W]),
      .funcOut(perOut[p*NUM_FUNCS +: NUM_FUNCS]),
      .funcOe(perOe[p*NUM_FUNCS +: NUM_FUNCS]),
      .pinOut(padOut[p]), .pinOe(padOe[p])
    );
  end
endmodule

// File: rtl/gpioCommitPortChk.sv
module gpioCommitPortChk #(
  parameter int                  NUM_PINS  = 8,
  parameter int                  DATA_W    = 32,
  parameter logic [NUM_PINS-1:0] PROT_MASK = 8'h8F
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWr,
  input logic [3:0]          busAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic                lockOpen,
  input logic [NUM_PINS-1:0] commitQ,
  input logic [NUM_PINS-1:0] altQ,
  input logic [NUM_PINS-1:0] denQ,
  input logic [NUM_PINS-1:0] dirQ,
  input logic [NUM_PINS-1:0] padOe
);
  // R4
  lock_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 4'd8 && busWdata == DATA_W'(32'h4C4F434B)) |=> lockOpen);

  // R4
  lock_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 4'd8 && busWdata != DATA_W'(32'h4C4F434B)) |=> !lockOpen);

  // R5
  commit_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitQ | PROT_MASK) == {NUM_PINS{1'b1}});

  // R5
  commit_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockOpen |=> $stable(commitQ));

  // R6
  prot_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockOpen |=> ((altQ & PROT_MASK) == ($past(altQ) & PROT_MASK)));

  // R6
  prot_den_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockOpen |=> ((denQ & PROT_MASK) == ($past(denQ) & PROT_MASK)));

  // R2
  sw_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~altQ) == (dirQ & ~altQ));
endmodule

bind gpioCommitPort gpioCommitPortChk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .PROT_MASK(PROT_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .lockOpen(lockOpen), .commitQ(commitQ),
  .altQ(altQ), .denQ(denQ), .dirQ(dirQ), .padOe(padOe)
);

// File: tb/gpioCommitPort_tb.sv
module gpioCommitPort_tb;
  localparam logic [7:0]  PROT = 8'h8F;
  localparam logic [31:0] KEY  = 32'h4C4F434B;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWr = 1'b0;
  logic [3:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [7:0]   padIn = '0;
  logic [7:0]   padOut, padOe, padPullUp, padPullDn, padAnaEn, perIn;
  logic [127:0] perOut = '0;
  logic [127:0] perOe = '0;

  int checks = 0;
  int fails = 0;

  logic [7:0]  mData, mDir, mAlt, mPu, mPd, mDen, mAna, mCommit;
  logic [31:0] mCtl;
  logic        mOpen;

  always #4 clk = ~clk;

  gpioCommitPort u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp),
    .padPullDn(padPullDn), .padAnaEn(padAnaEn), .perIn(perIn),
    .perOut(perOut), .perOe(perOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mData = '0; mDir = '0; mAlt = PROT; mPu = '0; mPd = '0;
    mDen = PROT; mAna = '0; mCommit = ~PROT; mOpen = 1'b0;
    mCtl = 32'h1000_1111;
  endtask

  function automatic logic [7:0] gate(input logic [7:0] oldV, input logic [7:0] newV);
    logic [7:0] allow;
    allow = ~PROT | (mOpen ? mCommit : 8'h00);
    return (oldV & ~allow) | (newV & allow);
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] a);
    logic [7:0] sw;
    sw = ~mAlt & mDir;
    case (a)
      4'd0: return {24'h0, (mData & sw) | (padIn & mDen & ~sw)};
      4'd1: return {24'h0, mDir};
      4'd2: return {24'h0, mAlt};
      4'd3: return {24'h0, mPu};
      4'd4: return {24'h0, mPd};
      4'd5: return {24'h0, mDen};
      4'd6: return {24'h0, mAna};
      4'd7: return mCtl;
      4'd8: return {31'h0, !mOpen};
      4'd9: return {24'h0, mCommit};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] expPads();
    logic [7:0] o, e;
    for (int p = 0; p < 8; p++) begin
      logic [3:0] s;
      s = mCtl[p*4 +: 4];
      if (!mAlt[p]) begin o[p] = mData[p]; e[p] = mDir[p]; end
      else if (s == 4'd0) begin o[p] = 1'b0; e[p] = 1'b0; end
      else begin o[p] = perOut[p*16 + int'(s)]; e[p] = perOe[p*16 + int'(s)]; end
    end
    return {o, e};
  endfunction

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busWr = 1'b0;
    case (a)
      4'd0: mData = d[7:0];
      4'd1: mDir = d[7:0];
      4'd2: mAlt = gate(mAlt, d[7:0]);
      4'd3: mPu = gate(mPu, d[7:0]);
      4'd4: mPd = gate(mPd, d[7:0]);
      4'd5: mDen = gate(mDen, d[7:0]);
      4'd6: mAna = d[7:0];
      4'd7: mCtl = d;
      4'd8: mOpen = (d == KEY);
      4'd9: if (mOpen) mCommit = d[7:0] | ~PROT;
      default: ;
    endcase
  endtask

  task automatic readChk(input string req, input logic [3:0] a);
    @(negedge clk);
    busAddr = a;
    #1 chk(req, busRdata, expRead(a));
  endtask

  task automatic padChk();
    @(negedge clk);
    padIn = 8'($urandom);
    perOut = {$urandom, $urandom, $urandom, $urandom};
    perOe = {$urandom, $urandom, $urandom, $urandom};
    #1;
    chk("R2/R3 padOut", {24'h0, padOut}, {24'h0, expPads() >> 8});
    chk("R2/R3 padOe", {24'h0, padOe}, {24'h0, expPads() & 16'hFF});
    chk("R8 perIn", {24'h0, perIn}, {24'h0, padIn & mDen});
    chk("R9 pads", {8'h0, padAnaEn, padPullUp, padPullDn}, {8'h0, mAna, mPu, mPd});
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values of every register
    for (int a = 0; a < 16; a++) readChk("R1", 4'(a));
    padChk();

    // R6: protected write while closed keeps protected bits, unprotected take effect
    busWrite(4'd2, 32'h0000_0000);
    readChk("R6 closed", 4'd2);
    // R5: commit write while closed discarded
    busWrite(4'd9, 32'h0000_00FF);
    readChk("R5 closed", 4'd9);
    // R4: open with key
    busWrite(4'd8, KEY);
    readChk("R4 open", 4'd8);
    // R6: open but commit clear still discards
    busWrite(4'd5, 32'h0000_0000);
    readChk("R6 no commit", 4'd5);
    // R5: commit partial; unprotected bits stay 1
    busWrite(4'd9, 32'h0000_0003);
    readChk("R5 partial", 4'd9);
    busWrite(4'd2, 32'h0000_0000);
    readChk("R6 partial", 4'd2);
    // R4: any other value relocks
    busWrite(4'd8, 32'h4C4F434A);
    readChk("R4 relock", 4'd8);
    busWrite(4'd2, 32'h0000_00FF);
    readChk("R6 relocked", 4'd2);
    // R3: alternate mode with selector 0 is idle
    busWrite(4'd7, 32'h0000_0000);
    padChk();
    // R7 unconditional registers
    busWrite(4'd1, 32'h0000_00A5);
    readChk("R7 dir", 4'd1);
    busWrite(4'd6, 32'h0000_005A);
    readChk("R7 ana", 4'd6);
    busWrite(4'd7, 32'h7654_3210);
    readChk("R7 ctl", 4'd7);
    busWrite(4'd0, 32'h0000_00C3);
    readChk("R10 data", 4'd0);
    padChk();
    readChk("R10 unmapped", 4'd12);

    // Random phase
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      a = 4'($urandom_range(0, 11));
      d = $urandom;
      if (a == 4'd8 && ($urandom_range(0, 2) != 0)) d = KEY;
      busWrite(a, d);
      readChk("R6/R7/R10 random", 4'($urandom_range(0, 15)));
      if (i % 4 == 0) padChk();
    end
    finishRun();
  end
endmodule